// File: doc/BRIEF.md
# Partial-Update Gate Clock Sequencer

This block produces the vertical gate clock and the per-row enable pulse for one frame of a 320-row memory-pixel panel. It never scans unchanged rows at full speed. A stream of 32-bit run lengths describes the frame as alternating stretches of untouched rows and rewritten rows. Untouched rows are passed with a single fast toggle of the gate clock. Rewritten rows get full-length gate half-periods, and each of those half-periods carries an enable pulse. A partial frame therefore costs little more than the rows that actually changed.

Time is counted in ticks from an external enable. One full gate half-period lasts `HALF_TICKS` ticks. When a rewritten stretch begins, the block raises a one-cycle strobe so that a separate horizontal data shifter starts sending that stretch's pixels. The frame envelope, the final gate pulses and the pixel serialisation are handled elsewhere. An end-of-frame override input returns the sequencer to idle when the logic that drives the last pulses takes over.

Top module: `gck_partial_seq`

## Requirements
- R1: After reset, `gck`, `gen`, `data_start`, `busy` and `cnt_ready` are all low.
- R2: A `start` pulse while idle opens the frame with two full half-periods, each `HALF_TICKS` ticks long: the first with `gck` high, the second with `gck` low. Neither half carries `gen`.
- R3: Run words are consumed in the order untouched, rewritten, untouched, rewritten and so on. A word of value v stands for v+1 rows.
- R4: Each untouched row is one tick with `gck` low followed by one tick with `gck` high, and it carries no `gen`.
- R5: If the first word is zero, the second opening half becomes the lead-in of a rewritten stretch. That half raises `data_start` and carries no `gen`.
- R6: A rewritten stretch is one lead-in half with `gck` low and no `gen`, followed by v+1 pairs of full halves, high then low. In every half of a pair, `gen` is high exactly on ticks 8 to 23, counting the first tick of the half as 0.
- R7: `data_start` is high for exactly one clock, in the first clock of each lead-in half.
- R8: At the end of the last low half of a rewritten stretch, the next untouched-run word is taken at once, and the first untouched row begins on the following tick.
- R9: When the next word is needed and none is offered, `gck` and `gen` hold their levels and the position in the frame does not advance. The block takes exactly the words offered and never more.
- R10: `busy` rises with `start` and stays high until `end_ovr` is sampled high. On the clock after that, `busy`, `gck`, `gen` and `cnt_ready` are low.
- R11: On a clock edge where `tick` is low, the gate clock and the enable pulse do not change.
- R12: A `start` pulse while `busy` is high has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timing enable, 1/HALF_TICKS of a full half-period |
| start | input | 1 | Begins a frame when idle |
| end_ovr | input | 1 | End-of-frame override, returns to idle |
| cnt_valid | input | 1 | Run word offered |
| cnt_data | input | CNT_W | Run word, rows minus one |
| cnt_ready | output | 1 | Run word accepted when high together with cnt_valid |
| gck | output | 1 | Vertical gate clock |
| gen | output | 1 | Row enable pulse |
| data_start | output | 1 | One-clock cue to the horizontal data shifter |
| busy | output | 1 | Frame in progress |

## Verification
The hardest states to reach are the stalls at each point where a word is needed: the end of the first half, the end of a lead-in and the end of a rewritten stretch. In these stalls the frame must freeze and must not move on to another word. The bench reaches each of them by ending the word list at different positions, and it sweeps small first-run and change-run lengths with and without a leading zero word. One frame runs with a slow tick, so that the freeze between ticks and the single-clock strobe are checked while the same tick value is held for several clocks.

// File: rtl/gck_seq_pkg.sv
package gck_seq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LEAD_HI,
      ST_LEAD_LO,
      ST_SKIP_LO,
      ST_SKIP_HI,
      ST_CHG_IN,
      ST_CHG_HI,
      ST_CHG_LO
   } seq_state_e;
endpackage

// File: rtl/gck_word_buf.sv
// One-entry holding register for the run-length stream; empties on take.
module gck_word_buf #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         flush,
   input  logic         in_valid,
   input  logic [W-1:0] in_data,
   output logic         in_ready,
   input  logic         take,
   output logic         out_vld,
   output logic [W-1:0] out_data
);
   logic         full_q;
   logic [W-1:0] data_q;

   assign in_ready = !flush && !full_q;
   assign out_vld  = full_q;
   assign out_data = data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q <= 1'b0;
         data_q <= '0;
      end else if (flush) begin
         full_q <= 1'b0;
      end else if (in_valid && in_ready) begin
         full_q <= 1'b1;
         data_q <= in_data;
      end else if (take) begin
         full_q <= 1'b0;
      end
   end
endmodule

// File: rtl/gck_half_timer.sv
// Tick position inside a gate half-period, with the enable-pulse window.
module gck_half_timer #(
   parameter int HALF_TICKS = 32,
   parameter int GEN_START  = 8,
   parameter int GEN_WIDTH  = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic adv,
   output logic half_end,
   output logic gen_win
);
   localparam int TW   = (HALF_TICKS > 2) ? $clog2(HALF_TICKS) : 1;
   localparam bit POW2 = ((1 << TW) == HALF_TICKS);
   localparam logic [TW-1:0] LAST = TW'(HALF_TICKS - 1);
   localparam logic [31:0]   WLO  = 32'(GEN_START);
   localparam logic [31:0]   WHI  = 32'(GEN_START + GEN_WIDTH);

   logic [TW-1:0] tc_q;
   logic [31:0]   tc_w;

   generate
      if (POW2) begin : g_wrap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       tc_q <= '0;
            else if (restart) tc_q <= '0;
            else if (adv)     tc_q <= tc_q + TW'(1);
         end
      end else begin : g_cmp
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       tc_q <= '0;
            else if (restart) tc_q <= '0;
            else if (adv)     tc_q <= (tc_q == LAST) ? '0 : tc_q + TW'(1);
         end
      end
   endgenerate

   assign tc_w     = {{(32-TW){1'b0}}, tc_q};
   assign half_end = (tc_q == LAST);
   assign gen_win  = (tc_w >= WLO) && (tc_w < WHI);
endmodule

// File: rtl/gck_seq_ctrl.sv
// Frame walk: opening halves, untouched-row toggles, rewritten stretches.
module gck_seq_ctrl
   import gck_seq_pkg::*;
#(
   parameter int CW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          start,
   input  logic          end_ovr,
   input  logic          word_vld,
   input  logic [CW-1:0] word,
   input  logic          half_end,
   output logic          word_take,
   output logic          restart,
   output logic          adv,
   output seq_state_e    state,
   output logic          data_start
);
   seq_state_e    st_q, st_d;
   logic [CW-1:0] run_q, run_d;
   logic          stall;
   logic          ds_q;

   always_comb begin
      st_d      = st_q;
      run_d     = run_q;
      word_take = 1'b0;
      restart   = 1'b0;
      stall     = 1'b0;
      if (st_q == ST_IDLE) begin
         if (start) begin
            st_d    = ST_LEAD_HI;
            restart = 1'b1;
         end
      end else if (end_ovr) begin
         st_d    = ST_IDLE;
         restart = 1'b1;
      end else if (tick) begin
         unique case (st_q)
            ST_LEAD_HI: if (half_end) begin
               if (word_vld) begin
                  word_take = 1'b1;
                  restart   = 1'b1;
                  if (word == '0) begin
                     st_d = ST_CHG_IN;
                  end else begin
                     st_d  = ST_LEAD_LO;
                     run_d = word;
                  end
               end else begin
                  stall = 1'b1;
               end
            end
            ST_LEAD_LO: if (half_end) begin
               st_d    = ST_SKIP_LO;
               restart = 1'b1;
            end
            ST_SKIP_LO: begin
               st_d    = ST_SKIP_HI;
               restart = 1'b1;
            end
            ST_SKIP_HI: begin
               restart = 1'b1;
               if (run_q == '0) begin
                  st_d = ST_CHG_IN;
               end else begin
                  run_d = run_q - CW'(1);
                  st_d  = ST_SKIP_LO;
               end
            end
            ST_CHG_IN: if (half_end) begin
               if (word_vld) begin
                  word_take = 1'b1;
                  run_d     = word;
                  st_d      = ST_CHG_HI;
                  restart   = 1'b1;
               end else begin
                  stall = 1'b1;
               end
            end
            ST_CHG_HI: if (half_end) begin
               st_d    = ST_CHG_LO;
               restart = 1'b1;
            end
            ST_CHG_LO: if (half_end) begin
               if (run_q != '0) begin
                  run_d   = run_q - CW'(1);
                  st_d    = ST_CHG_HI;
                  restart = 1'b1;
               end else if (word_vld) begin
                  word_take = 1'b1;
                  run_d     = word;
                  st_d      = ST_SKIP_LO;
                  restart   = 1'b1;
               end else begin
                  stall = 1'b1;
               end
            end
            default: st_d = ST_IDLE;
         endcase
      end
      adv = tick && (st_q != ST_IDLE) && !end_ovr && !stall && !restart;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         run_q <= '0;
         ds_q  <= 1'b0;
      end else begin
         st_q  <= st_d;
         run_q <= run_d;
         ds_q  <= (st_d == ST_CHG_IN) && (st_q != ST_CHG_IN);
      end
   end

   assign state      = st_q;
   assign data_start = ds_q;
endmodule

// File: rtl/gck_partial_seq.sv
module gck_partial_seq
   import gck_seq_pkg::*;
#(
   parameter int CNT_W      = 32,
   parameter int HALF_TICKS = 32,
   parameter int GEN_START  = 8,
   parameter int GEN_WIDTH  = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             start,
   input  logic             end_ovr,
   input  logic             cnt_valid,
   input  logic [CNT_W-1:0] cnt_data,
   output logic             cnt_ready,
   output logic             gck,
   output logic             gen,
   output logic             data_start,
   output logic             busy
);
   generate
      if (HALF_TICKS < 4) begin : g_bad_half
         $error("HALF_TICKS must be at least 4");
      end
      if (GEN_WIDTH < 1 || GEN_START < 1 || GEN_START + GEN_WIDTH > HALF_TICKS) begin : g_bad_gen
         $error("enable window must lie strictly inside a half-period");
      end
      if (CNT_W < 2) begin : g_bad_cw
         $error("CNT_W must be at least 2");
      end
   endgenerate

   seq_state_e       state;
   logic             word_vld, word_take;
   logic [CNT_W-1:0] word;
   logic             restart, adv, half_end, gen_win;
   logic             in_pair;

   assign busy = (state != ST_IDLE);

   gck_word_buf #(.W(CNT_W)) u_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (!busy),
      .in_valid (cnt_valid),
      .in_data  (cnt_data),
      .in_ready (cnt_ready),
      .take     (word_take),
      .out_vld  (word_vld),
      .out_data (word)
   );

   gck_half_timer #(
      .HALF_TICKS (HALF_TICKS),
      .GEN_START  (GEN_START),
      .GEN_WIDTH  (GEN_WIDTH)
   ) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (restart),
      .adv      (adv),
      .half_end (half_end),
      .gen_win  (gen_win)
   );

   gck_seq_ctrl #(.CW(CNT_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .start      (start),
      .end_ovr    (end_ovr),
      .word_vld   (word_vld),
      .word       (word),
      .half_end   (half_end),
      .word_take  (word_take),
      .restart    (restart),
      .adv        (adv),
      .state      (state),
      .data_start (data_start)
   );

   assign in_pair = (state == ST_CHG_HI) || (state == ST_CHG_LO);
   assign gck     = (state == ST_LEAD_HI) || (state == ST_SKIP_HI) || (state == ST_CHG_HI);
   assign gen     = in_pair && gen_win;
endmodule

// File: rtl/gck_partial_seq_chk.sv
module gck_partial_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic tick,
   input logic end_ovr,
   input logic cnt_ready,
   input logic gck,
   input logic gen,
   input logic data_start,
   input logic busy
);
   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!gck && !gen && !data_start && !cnt_ready));

   p_busy_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !end_ovr) |=> busy);

   p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && end_ovr) |=> !busy);

   p_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !tick && !end_ovr) |=> ($stable(gck) && $stable(gen)));

   p_strobe_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      data_start |=> !data_start);

   p_leadin_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      data_start |-> (!gck && !gen && busy));

   p_gen_mid_half_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gen) |-> $stable(gck));

   p_gen_in_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
      gen |-> busy);
endmodule

bind gck_partial_seq gck_partial_seq_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tick       (tick),
   .end_ovr    (end_ovr),
   .cnt_ready  (cnt_ready),
   .gck        (gck),
   .gen        (gen),
   .data_start (data_start),
   .busy       (busy)
);

// File: tb/tb_gck_partial_seq.sv
module tb_gck_partial_seq;
   localparam int CLK_PERIOD = 10;
   localparam int HT = 32;
   localparam int GS = 8;
   localparam int GW = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        start = 1'b0;
   logic        end_ovr = 1'b0;
   logic        cnt_valid = 1'b0;
   logic [31:0] cnt_data = '0;
   logic        cnt_ready, gck, gen, data_start, busy;

   int n_vec = 0;
   int n_bad = 0;
   logic [2:0] expq[$];
   int words[$];

   gck_partial_seq dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .end_ovr(end_ovr),
      .cnt_valid(cnt_valid), .cnt_data(cnt_data), .cnt_ready(cnt_ready),
      .gck(gck), .gen(gen), .data_start(data_start), .busy(busy)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   // expected entry per tick: {data_start, gen, gck}
   task automatic push_half(input bit lvl, input bit g, input bit ds);
      for (int t = 0; t < HT; t++)
         expq.push_back({ds && (t == 0), g && (t >= GS) && (t < GS + GW), lvl});
   endtask

   task automatic push_skip(input int s);
      for (int l = 0; l <= s; l++) begin
         expq.push_back(3'b000);
         expq.push_back(3'b001);
      end
   endtask

   task automatic build();
      int i;
      int c;
      int s;
      expq.delete();
      push_half(1'b1, 1'b0, 1'b0);
      if (words.size() == 0) return;
      s = words[0];
      i = 1;
      if (s != 0) begin
         push_half(1'b0, 1'b0, 1'b0);
         push_skip(s);
      end
      push_half(1'b0, 1'b0, 1'b1);
      forever begin
         if (i >= words.size()) return;
         c = words[i];
         i++;
         for (int l = 0; l <= c; l++) begin
            push_half(1'b1, 1'b1, 1'b0);
            push_half(1'b0, 1'b1, 1'b0);
         end
         if (i >= words.size()) return;
         s = words[i];
         i++;
         push_skip(s);
         push_half(1'b0, 1'b0, 1'b1);
      end
   endtask

   task automatic run_frame(input int tick_per);
      int idx;
      int wi;
      int k;
      int prev_idx;
      bit acc;
      bit tprev;
      logic [2:0] e;
      build();
      @(negedge clk);
      start = 1'b1;
      cnt_valid = 1'b0;
      tick = (tick_per == 1);
      tprev = tick;
      @(negedge clk);
      idx = 0; wi = 0; k = 0; acc = 1'b0; prev_idx = -1;
      while (idx < expq.size() + 20) begin
         if (k > 0 && tprev) idx++;
         if (acc) wi++;
         cnt_valid = (wi < words.size());
         cnt_data  = cnt_valid ? words[wi] : 32'd0;
         start = (idx == expq.size() + 5); // R12: restart attempt while busy
         #1;
         acc = cnt_valid && cnt_ready;
         e = (idx < expq.size()) ? expq[idx] : {2'b00, expq[expq.size()-1][0]};
         check("gck R2 R3 R4 R6 R8 R9 R11 R12", {31'd0, gck}, {31'd0, e[0]});
         check("gen R2 R4 R6 R11", {31'd0, gen}, {31'd0, e[1]});
         check("data_start R5 R7", {31'd0, data_start}, {31'd0, e[2] && (idx != prev_idx)});
         check("busy R10", {31'd0, busy}, 32'd1);
         prev_idx = idx;
         tick = (((k + 1) % tick_per) == 0);
         tprev = tick;
         k++;
         @(negedge clk);
      end
      start = 1'b0;
      check("words taken R3 R9", wi + (acc ? 1 : 0), words.size());
      cnt_valid = 1'b0;
      end_ovr = 1'b1;
      @(negedge clk);
      end_ovr = 1'b0;
      #1;
      check("busy after override R10", {31'd0, busy}, 32'd0);
      check("gck after override R10", {31'd0, gck}, 32'd0);
      check("gen after override R10", {31'd0, gen}, 32'd0);
      check("ready after override R10", {31'd0, cnt_ready}, 32'd0);
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_vec++;
      n_bad++;
      $display("FAIL watchdog R10 actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 2 + 1);
      check("reset gck R1", {31'd0, gck}, 32'd0);
      check("reset gen R1", {31'd0, gen}, 32'd0);
      check("reset data_start R1", {31'd0, data_start}, 32'd0);
      check("reset busy R1", {31'd0, busy}, 32'd0);
      check("reset ready R1", {31'd0, cnt_ready}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // sweep of opening skip and first change lengths
      for (int s0 = 0; s0 < 4; s0++) begin
         for (int c0 = 0; c0 < 3; c0++) begin
            words = '{s0, c0, 1};
            run_frame(1);
         end
      end
      // two stretches, stream ends after a change
      words = '{3, 2, 4, 1};
      run_frame(1);
      // leading zero with a later skip
      words = '{0, 1, 2, 0};
      run_frame(1);
      // stall waiting for the change word after a zero start
      words = '{0};
      run_frame(1);
      // stall in a lead-in after untouched rows
      words = '{5};
      run_frame(1);
      // stall in the first half with no words
      words.delete();
      run_frame(1);
      // slow tick
      words = '{2, 1, 0, 0};
      run_frame(3);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule